// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the device end of a one-bit serial bus that configures a memory device. On every rising edge of the serial clock it samples a framing input and a serial data input. A framing pattern marks the start of a transaction. The block then shifts in 16-bit packets and decodes the opcode in the first packet. It serves the transaction only when the packet names this device's programmed identifier, or when the packet sets its broadcast flag.

Reads and writes take four back-to-back packets: a request, an address, an empty interval and a data packet. During that sequence the block writes a small bank of 16-bit registers, or sends a register's contents out in place of the data packet. Three single-packet commands control the rest:

- Set-reset returns every register to its reset value and blocks the bank.
- Clear-reset releases the bank again.
- Set-fast-clock raises a mode flag.

All other serial input is passed through, one cycle later, on the serial output that feeds the next device in a chain.

Top module: `sreg_slave`

## Requirements
- R1: A transaction starts at a rising edge where `cmd_i` is sampled low after at least four consecutive high samples. That edge also captures packet bit 0 from `sin_i`, and the following edges capture the remaining bits. While a transaction is in progress `cmd_i` is ignored. A run of three or fewer high samples starts nothing.
- R2: Each packet carries 16 bits, most significant first. In the request packet, bits 0 to 4 are reserved. Bit 5 is device-select bit 5. Bits 6 to 9 are opcode bits 3 down to 0. Bit 10 is the broadcast flag. Bits 11 to 15 are device-select bits 4 down to 0.
- R3: A request is acted on only when its 6-bit device field equals `dev_id_i` or its broadcast flag is 1. Otherwise it has no effect on registers or flags.
- R4: Opcode 0001 is a write: request, address, interval and data packets follow without gaps. The register address is bits 4 to 15 of the address packet. A selected write stores the 16-bit data packet.
- R5: Opcode 0000 is a read with the same four-packet shape. For a selected read, `sout_o` carries the addressed register, MSB first, during the data packet. Each output bit appears one cycle after the input bit it replaces.
- R6: Outside the data packet of a selected read, `sout_o` equals `sin_i` delayed by one clock. This covers an unselected read.
- R7: The bank holds `NREGS` registers (default 8) at addresses 0 to `NREGS`-1. A write to any other address is ignored, and a read of any other address returns zero.
- R8: After `rst_n` is held low, `sout_o`, `fast_o` and `rst_hold_o` are 0, and register i holds i times `RST_STEP` (default 16'h1111).
- R9: Opcode 0010 (set-reset) reloads every register with its reset value, sets `rst_hold_o` and clears `fast_o`. While `rst_hold_o` is 1, writes are ignored and reads return zero.
- R10: Opcode 1011 (clear-reset) clears `rst_hold_o`. When `rst_hold_o` is already 0 it has no effect.
- R11: Opcode 0100 (set-fast-clock) sets `fast_o`. The two flags change only at the last bit of a request packet.
- R12: Opcode 1111 and the reserved opcodes change nothing and occupy only the request packet. A new transaction can be framed right after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 1 | Framing input |
| sin_i | input | 1 | Serial data from the previous device |
| dev_id_i | input | 6 | Programmed device identifier |
| sout_o | output | 1 | Serial data to the next device, or read data |
| fast_o | output | 1 | Fast-clock mode flag |
| rst_hold_o | output | 1 | Set while the bank is held after set-reset |

## Verification
The assertions assume that `cmd_i` stays low for the whole of a transaction. They also assume that read and write transactions are always sent as four unbroken packets, so that the data-phase and flag checks line up with packet boundaries. The stimulus follows these assumptions: each framing pattern comes only after the previous transaction and two idle cycles. The one deliberately short framing pattern is followed by a complete, well-formed packet sequence with `cmd_i` held low, which the block must treat as noise.

// File: rtl/sreg_pkg.sv
// Shared constants for the serial control register slave.
// Assumes: 4-bit opcodes, 16-bit packets, 6-bit device identifiers.
package sreg_pkg;
    localparam int PKT_BITS   = 16;
    localparam int PKT_PER_RW = 4;
    localparam int DEV_W      = 6;
    localparam int ADDR_W     = 12;

    localparam logic [3:0] OP_READ  = 4'b0000;
    localparam logic [3:0] OP_WRITE = 4'b0001;
    localparam logic [3:0] OP_SETR  = 4'b0010;
    localparam logic [3:0] OP_SETF  = 4'b0100;
    localparam logic [3:0] OP_CLRR  = 4'b1011;
endpackage

// File: rtl/sreg_framer.sv
// Frame detector and bit sequencer.
// Starts a transaction when cmd_i falls after FRAME_HIGH or more high samples.
// It then counts bit positions and presents each packet word with the current bit.
// Assumes: long_i is valid in the cycle of the last request bit.
module sreg_framer #(
    parameter int PKT        = 16,
    parameter int NPKT       = 4,
    parameter int FRAME_HIGH = 4,
    localparam int TXN = PKT * NPKT,
    localparam int PW  = $clog2(TXN),
    localparam int HW  = $clog2(FRAME_HIGH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_i,
    input  logic           sin_i,
    input  logic           long_i,
    output logic           start_o,
    output logic           vld_o,
    output logic [PW-1:0]  pos_o,
    output logic [PKT-1:0] word_o
);
    logic [HW-1:0]  hi_cnt;
    logic           active;
    logic [PW-1:0]  pos;
    logic [PKT-2:0] sh;
    logic           last;

    // Combinational view of the current bit and its position.
    always_comb begin
        start_o = !active && !cmd_i && (hi_cnt == HW'(FRAME_HIGH));
        vld_o   = active || start_o;
        pos_o   = active ? pos : '0;
        word_o  = {sh, sin_i};
        last    = (pos_o == PW'(PKT - 1) && !long_i) || (pos_o == PW'(TXN - 1));
    end

    // Saturating count of consecutive high framing samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!cmd_i)
            hi_cnt <= '0;
        else if (hi_cnt != HW'(FRAME_HIGH))
            hi_cnt <= hi_cnt + 1'b1;
    end

    // Bit position, activity flag and packet shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
            sh     <= '0;
        end else if (vld_o) begin
            sh <= word_o[PKT-2:0];
            if (last) begin
                active <= 1'b0;
                pos    <= '0;
            end else begin
                active <= 1'b1;
                pos    <= pos_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sreg_req_dec.sv
// Request packet decoder: extracts the opcode and decides device selection.
// Assumes: hdr_i is the low 11 bits of a complete request word (reserved bits dropped).
module sreg_req_dec
    import sreg_pkg::*;
(
    input  logic [10:0]      hdr_i,
    input  logic [DEV_W-1:0] dev_id_i,
    output logic [3:0]       op_o,
    output logic             sel_o,
    output logic             rw_o
);
    logic [DEV_W-1:0] dev;

    // Field extraction, selection and transaction length.
    always_comb begin
        op_o  = hdr_i[9:6];
        dev   = {hdr_i[10], hdr_i[4:0]};
        sel_o = (dev == dev_id_i) || hdr_i[5];
        rw_o  = (op_o == OP_READ) || (op_o == OP_WRITE);
    end
endmodule

// File: rtl/sreg_bank.sv
// Bank of NREGS 16-bit control registers.
// Register g resets or reloads to g*RST_STEP.
// Assumes: an out-of-range address reads zero and writes nowhere.
module sreg_bank #(
    parameter int          NREGS    = 8,
    parameter int          DW       = 16,
    parameter int          AW       = 12,
    parameter int unsigned RST_STEP = 32'h1111,
    localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [NREGS*DW-1:0] flat;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [DW-1:0] RV = DW'(g * RST_STEP);
        logic [DW-1:0] q;

        // One register: reset or reload value, else an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n || reload_i)
                q <= RV;
            else if (wr_en_i && waddr_i == AW'(g))
                q <= wdata_i;
        end

        assign flat[g*DW +: DW] = q;
    end

    // Read mux with a zero result for unmapped addresses.
    always_comb begin
        if (raddr_i < AW'(NREGS))
            rdata_o = flat[raddr_i[IW-1:0]*DW +: DW];
        else
            rdata_o = '0;
    end
endmodule

// File: rtl/sreg_slave.sv
// Serial control register slave (top).
// Frames and decodes serial transactions, runs the reset-hold sequence,
// serves register reads and writes and repeats serial data down the chain.
// Assumes: cmd_i stays low during a transaction.
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int          NREGS    = 8,
    parameter int unsigned RST_STEP = 32'h1111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic             sin_i,
    input  logic [DEV_W-1:0] dev_id_i,
    output logic             sout_o,
    output logic             fast_o,
    output logic             rst_hold_o
);
    localparam int TXN = PKT_BITS * PKT_PER_RW;
    localparam int PW  = $clog2(TXN);

    logic                frame_start, vld, sel, rw;
    logic [PW-1:0]       pos;
    logic [PKT_BITS-1:0] word, rdata, rd_sh;
    logic [3:0]          op;
    logic                req_done, adr_done, dat_done, rd_phase;
    logic                txn_sel, txn_rd, reload, wr_en;
    logic [ADDR_W-1:0]   addr_q;

    sreg_framer #(.PKT(PKT_BITS), .NPKT(PKT_PER_RW), .FRAME_HIGH(4)) u_framer (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .sin_i(sin_i), .long_i(rw),
        .start_o(frame_start), .vld_o(vld), .pos_o(pos), .word_o(word)
    );

    sreg_req_dec u_dec (
        .hdr_i(word[10:0]), .dev_id_i(dev_id_i), .op_o(op), .sel_o(sel), .rw_o(rw)
    );

    sreg_bank #(.NREGS(NREGS), .DW(PKT_BITS), .AW(ADDR_W), .RST_STEP(RST_STEP)) u_bank (
        .clk(clk), .rst_n(rst_n), .reload_i(reload), .wr_en_i(wr_en),
        .waddr_i(addr_q), .wdata_i(word), .raddr_i(word[ADDR_W-1:0]), .rdata_o(rdata)
    );

    // Packet boundary strobes and bank controls.
    always_comb begin
        req_done = vld && (pos == PW'(PKT_BITS - 1));
        adr_done = vld && (pos == PW'(2 * PKT_BITS - 1));
        dat_done = vld && (pos == PW'(TXN - 1));
        rd_phase = vld && (pos >= PW'(3 * PKT_BITS)) && txn_sel && txn_rd;
        reload   = req_done && sel && (op == OP_SETR);
        wr_en    = dat_done && txn_sel && !txn_rd && !rst_hold_o;
    end

    // Mode flags and per-transaction selection, updated on the request's last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_hold_o <= 1'b0;
            fast_o     <= 1'b0;
            txn_sel    <= 1'b0;
            txn_rd     <= 1'b0;
        end else if (req_done) begin
            txn_sel <= sel;
            txn_rd  <= (op == OP_READ);
            if (sel) begin
                case (op)
                    OP_SETR: begin rst_hold_o <= 1'b1; fast_o <= 1'b0; end
                    OP_CLRR: rst_hold_o <= 1'b0;
                    OP_SETF: fast_o <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Address latch and read-data shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_sh  <= '0;
        end else if (adr_done) begin
            addr_q <= word[ADDR_W-1:0];
            rd_sh  <= (txn_sel && txn_rd && !rst_hold_o) ? rdata : '0;
        end else if (rd_phase) begin
            rd_sh <= {rd_sh[PKT_BITS-2:0], 1'b0};
        end
    end

    // Serial output: read data during a selected read, else the repeated input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sout_o <= 1'b0;
        else
            sout_o <= rd_phase ? rd_sh[PKT_BITS-1] : sin_i;
    end
endmodule

// File: rtl/sreg_slave_chk.sv
// Assertion checker bound to sreg_slave.
// Assumes: cmd_i low during transactions.
module sreg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_i,
    input logic sin_i,
    input logic sout_o,
    input logic fast_o,
    input logic rst_hold_o,
    input logic frame_start,
    input logic req_done,
    input logic rd_phase
);
    // R1: a start needs four high framing samples followed by a low one.
    p_start_after_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!cmd_i && $past(cmd_i, 1) && $past(cmd_i, 2)
                         && $past(cmd_i, 3) && $past(cmd_i, 4)));

    // R6: outside read data, the output repeats the input one cycle later.
    p_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_phase) |-> (sout_o == $past(sin_i)));

    // R11: flags move only after the last request bit.
    p_flags_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_done) |-> ($stable(fast_o) && $stable(rst_hold_o)));

    // R9: entering the hold clears fast mode.
    p_setr_clears_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_hold_o) |-> !fast_o);

    // R9: reads during the hold return zero.
    p_hold_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_phase && rst_hold_o) |-> !sout_o);
endmodule

bind sreg_slave sreg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .sin_i(sin_i), .sout_o(sout_o),
    .fast_o(fast_o), .rst_hold_o(rst_hold_o), .frame_start(frame_start),
    .req_done(req_done), .rd_phase(rd_phase)
);

// File: tb/tb_sreg_slave.sv
// Bench for sreg_slave.
// It runs a behavioural per-clock reference model compared every cycle,
// plus directed scenario checks.
module tb_sreg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS      = 8;
    localparam logic [5:0] MY_ID    = 6'h2A;
    localparam logic [5:0] OTHER_ID = 6'h15;

    logic clk = 1'b0, rst_n = 1'b0, cmd = 1'b0, sin = 1'b0;
    logic sout, fast, hold;
    int   n_chk = 0, n_fail = 0;
    bit   cmp_on = 1'b0;

    sreg_slave #(.NREGS(NREGS), .RST_STEP(32'h1111)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .sin_i(sin), .dev_id_i(MY_ID),
        .sout_o(sout), .fast_o(fast), .rst_hold_o(hold)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit   m_q[$];
    int   m_hi, m_op, m_addr, m_rd;
    bit   m_busy, m_sel, m_sout, m_fast, m_hold;
    int   m_reg[NREGS];

    function automatic int last_word();
        int w = 0;
        for (int k = m_q.size() - 16; k < m_q.size(); k++) w = (w << 1) | int'(m_q[k]);
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_busy = 0; m_q.delete(); m_sout = 0; m_fast = 0; m_hold = 0;
            m_sel = 0; m_op = 15; m_addr = 0; m_rd = 0;
            for (int i = 0; i < NREGS; i++) m_reg[i] = i * 'h1111;
        end else begin
            bit nxt;
            int n, w;
            nxt = sin;
            if (!m_busy && !cmd && m_hi >= 4) m_busy = 1;
            if (m_busy) begin
                m_q.push_back(sin);
                n = m_q.size();
                if (n == 16) begin
                    w = last_word();
                    m_op  = (w >> 6) & 'hF;
                    m_sel = ((((w >> 5) & 'h20) | (w & 'h1F)) == int'(MY_ID)) || ((w >> 5) & 1);
                    if (m_sel) begin
                        if (m_op == 2) begin
                            m_hold = 1; m_fast = 0;
                            for (int i = 0; i < NREGS; i++) m_reg[i] = i * 'h1111;
                        end else if (m_op == 11) m_hold = 0;
                        else if (m_op == 4) m_fast = 1;
                    end
                    if (m_op > 1) begin m_busy = 0; m_q.delete(); end
                end
                if (n == 32) begin
                    m_addr = last_word() & 'hFFF;
                    m_rd = (m_sel && m_op == 0 && !m_hold && m_addr < NREGS) ? m_reg[m_addr] : 0;
                end
                if (n >= 49 && m_sel && m_op == 0) nxt = (m_rd >> (15 - (n - 49))) & 1;
                if (n == 64) begin
                    if (m_sel && m_op == 1 && !m_hold && m_addr < NREGS) m_reg[m_addr] = last_word();
                    m_busy = 0; m_q.delete();
                end
            end
            m_hi = cmd ? ((m_hi < 4) ? m_hi + 1 : 4) : 0;
            m_sout = nxt;
        end
    end

    // Compare against the model every cycle, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(sout == m_sout, "R5 R6 sout vs model", int'(sout), int'(m_sout));
            chk(fast == m_fast, "R11 fast vs model", int'(fast), int'(m_fast));
            chk(hold == m_hold, "R9 R10 hold vs model", int'(hold), int'(m_hold));
        end
    end

    // ---------------- stimulus ----------------
    task automatic frame(input int highs);
        for (int k = 0; k < highs; k++) begin
            cmd = 1'b1; sin = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        cmd = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w, output logic [15:0] echo);
        for (int i = 15; i >= 0; i--) begin
            sin = w[i];
            @(posedge clk); @(negedge clk);
            echo[i] = sout;
        end
    endtask

    function automatic logic [15:0] req(input logic [3:0] op, input bit bc, input logic [5:0] dev);
        return {5'b0, dev[5], op, bc, dev[4:0]};
    endfunction

    task automatic body(input logic [3:0] op, input bit bc, input logic [5:0] dev,
                        input logic [11:0] a, input logic [15:0] d, output logic [15:0] got);
        logic [15:0] e;
        send_word(req(op, bc, dev), e);
        got = 16'h0;
        if (op == 4'h0 || op == 4'h1) begin
            send_word({4'h0, a}, e);
            send_word(16'h0, e);
            send_word(d, got);
        end
        sin = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic txn(input logic [3:0] op, input bit bc, input logic [5:0] dev,
                       input logic [11:0] a, input logic [15:0] d, output logic [15:0] got);
        frame(4);
        body(op, bc, dev, a, d, got);
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] got);
        txn(4'h0, 1'b0, MY_ID, a, 16'h0, got);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk(sout == 1'b0 && fast == 1'b0 && hold == 1'b0, "R8 reset outputs",
            int'({sout, fast, hold}), 0);
        rd(12'h003, g);
        chk(g == 16'h3333, "R8 R5 reset value reg3", int'(g), 'h3333);

        txn(4'h1, 1'b0, MY_ID, 12'h002, 16'hA5C3, g);
        rd(12'h002, g);
        chk(g == 16'hA5C3, "R2 R4 write then read reg2", int'(g), 'hA5C3);

        txn(4'h1, 1'b0, OTHER_ID, 12'h002, 16'hFFFF, g);
        rd(12'h002, g);
        chk(g == 16'hA5C3, "R3 unselected write ignored", int'(g), 'hA5C3);
        txn(4'h1, 1'b1, OTHER_ID, 12'h001, 16'h1234, g);
        rd(12'h001, g);
        chk(g == 16'h1234, "R3 broadcast write", int'(g), 'h1234);

        txn(4'h1, 1'b0, MY_ID, 12'h800, 16'h5555, g);
        rd(12'h800, g);
        chk(g == 16'h0000, "R7 unmapped 0x800 reads zero", int'(g), 0);
        rd(12'h008, g);
        chk(g == 16'h0000, "R7 address NREGS reads zero", int'(g), 0);

        txn(4'h0, 1'b0, OTHER_ID, 12'h001, 16'hBEEF, g);
        chk(g == 16'hBEEF, "R6 unselected read repeats data", int'(g), 'hBEEF);

        frame(3);
        body(4'h1, 1'b0, MY_ID, 12'h002, 16'h0000, g);
        rd(12'h002, g);
        chk(g == 16'hA5C3, "R1 short frame starts nothing", int'(g), 'hA5C3);

        txn(4'h5, 1'b0, MY_ID, 12'h0, 16'h0, g);
        rd(12'h001, g);
        chk(g == 16'h1234, "R12 reserved op is one packet", int'(g), 'h1234);
        txn(4'hF, 1'b1, MY_ID, 12'h0, 16'h0, g);
        rd(12'h001, g);
        chk(g == 16'h1234 && !fast && !hold, "R12 nop no effect", int'(g), 'h1234);

        txn(4'h4, 1'b0, MY_ID, 12'h0, 16'h0, g);
        chk(fast == 1'b1, "R11 set-fast sets flag", int'(fast), 1);
        txn(4'h2, 1'b0, OTHER_ID, 12'h0, 16'h0, g);
        chk(hold == 1'b0 && fast == 1'b1, "R3 unselected set-reset ignored",
            int'({hold, fast}), 1);

        txn(4'h2, 1'b0, MY_ID, 12'h0, 16'h0, g);
        chk(hold == 1'b1 && fast == 1'b0, "R9 set-reset flags", int'({hold, fast}), 2);
        txn(4'h1, 1'b0, MY_ID, 12'h001, 16'h9999, g);
        rd(12'h001, g);
        chk(g == 16'h0000, "R9 read in hold is zero", int'(g), 0);
        txn(4'hB, 1'b0, MY_ID, 12'h0, 16'h0, g);
        chk(hold == 1'b0, "R10 clear-reset ends hold", int'(hold), 0);
        rd(12'h001, g);
        chk(g == 16'h1111, "R9 reload and blocked write", int'(g), 'h1111);
        rd(12'h002, g);
        chk(g == 16'h2222, "R9 reg2 reloaded", int'(g), 'h2222);
        txn(4'hB, 1'b0, MY_ID, 12'h0, 16'h0, g);
        rd(12'h001, g);
        chk(hold == 1'b0 && g == 16'h1111 && !fast, "R10 extra clear-reset no effect",
            int'(g), 'h1111);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule